// File: doc/BRIEF.md
# Keyed Restart Watchdog Timer

This block is a watchdog peripheral that sits on a simple APB-style register bus. Once software enables it, a down-counter runs from a power-of-two period. If software does not write the restart key to the restart register before the counter reaches zero, the watchdog expires. Any other value written to the restart register leaves the counter alone, so a runaway write loop cannot keep the timer alive by accident.

Expiry is handled in one of two ways. In direct mode the block drives its reset output high at once, for a programmable number of bus clocks. In staged mode the first expiry only raises an interrupt and starts a fresh period. The reset pulse follows only if that interrupt is still pending when the second period ends. Software clears the interrupt by reading a dedicated register. The first period after enabling can use a separate initial period selection, which gives a longer window at boot.

Bus accesses take no wait states. A transfer completes in the access phase (`psel` and `penable` both high). `prdata` is a combinational view of the register addressed by `paddr` and has no side effects, except for the read of the clear register.

Top module: `keyed_wdt`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `irq` is low and `wdt_rst` is low.
- R2: While enable (control bit 0, offset 0x00) is 1, the counter read at offset 0x08 drops by one each clock. While enable is 0, the counter holds its value.
- R3: A write that changes enable from 0 to 1 loads the counter with 2^(BASE_EXP+k)-1. Here k is the initial period field, bits 7:4 at offset 0x04.
- R4: While the block is enabled, a write to offset 0x0C whose low 8 bits equal 0x76 reloads the counter with 2^(BASE_EXP+j)-1. Here j is the running period field, bits 3:0 at offset 0x04.
- R5: A write to offset 0x0C with any other low byte is ignored, and the counter keeps counting down.
- R6: When an enabled counter is at zero, the watchdog expires. On the next clock the counter holds 2^(BASE_EXP+j)-1.
- R7: With mode (control bit 1) equal to 0, an expiry drives `wdt_rst` high from the next clock for exactly 2^(w+1) clocks. Here w is control bits 4:2, so the width runs from 2 to 256 clocks.
- R8: With mode equal to 1, an expiry while no interrupt is pending sets `irq` and status bit 0 at offset 0x10, and does not drive `wdt_rst`.
- R9: With mode equal to 1, an expiry while the interrupt is pending drives the reset pulse of R7, and the interrupt stays pending.
- R10: A read access to offset 0x14 clears the pending interrupt. The next expiry in mode 1 then raises the interrupt again and does not reset.
- R11: Control bits 4:0 and period bits 7:0 read back as written. Offsets 0x0C and 0x14 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for the register at `paddr` |
| irq | output | 1 | Pending first-stage expiry interrupt |
| wdt_rst | output | 1 | Active-high system reset pulse |

## Verification
Five behaviours are checked by assertions on every clock:
- The counter steps down by one per clock or holds while disabled.
- Every expiry leaves a reloaded, nonzero counter.
- Every rising edge of `wdt_rst` follows an expiry.
- The mode decides between setting the interrupt and issuing the reset.
- A read of the clear register drops the interrupt.

The exact reload values, the key comparison, the pulse widths counted in clocks, the register readback and the two-period sequence of staged mode need the bench's scenarios. The bench also needs a reference model that is compared with `prdata`, `irq` and `wdt_rst` on every clock.

// File: rtl/keyed_wdt_pkg.sv
// Package: shared register offsets, the restart key and the packed layouts
// of the control and period registers of the keyed watchdog.
// Assumes byte addressing, with every register on a 32-bit word.
package keyed_wdt_pkg;

    localparam int unsigned DATA_W = 32;

    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_RANGE  = 8'h04;
    localparam logic [7:0] OFF_COUNT  = 8'h08;
    localparam logic [7:0] OFF_KICK   = 8'h0C;
    localparam logic [7:0] OFF_STATUS = 8'h10;
    localparam logic [7:0] OFF_CLEAR  = 8'h14;

    localparam logic [7:0] KICK_KEY   = 8'h76;

    localparam int unsigned SEL_W  = 4;
    localparam int unsigned N_SEL  = 2 ** SEL_W;
    localparam int unsigned PW_W   = 3;

    // Control register, bit 0 upward: enable, mode, pulse width code
    typedef struct packed {
        logic [PW_W-1:0] pw;
        logic            mode;
        logic            en;
    } ctrl_t;

    // Period register: initial selection in the high nibble, running in the low
    typedef struct packed {
        logic [SEL_W-1:0] init_sel;
        logic [SEL_W-1:0] run_sel;
    } range_t;

endpackage

// File: rtl/keyed_wdt_regs.sv
// Module: register file and bus decode of the keyed watchdog.
// It holds the control and period registers and turns bus accesses into
// single-cycle strobes: enable rise, valid kick and interrupt clear.
// Assumes zero-wait accesses that complete when psel and penable are high.
module keyed_wdt_regs
    import keyed_wdt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              irq_pend,
    output logic [DATA_W-1:0] prdata,
    output ctrl_t             ctrl_q,
    output range_t            range_q,
    output logic              en_rise,
    output logic              kick,
    output logic              irq_clr
);

    logic wr_acc, rd_acc;
    logic hit_ctrl, hit_range, hit_count, hit_kick, hit_status, hit_clear;
    logic unused_hi;

    // Access phase qualifiers
    assign wr_acc = psel & penable &  pwrite;
    assign rd_acc = psel & penable & ~pwrite;

    // Address decode
    assign hit_ctrl   = (paddr == ADDR_W'(OFF_CTRL));
    assign hit_range  = (paddr == ADDR_W'(OFF_RANGE));
    assign hit_count  = (paddr == ADDR_W'(OFF_COUNT));
    assign hit_kick   = (paddr == ADDR_W'(OFF_KICK));
    assign hit_status = (paddr == ADDR_W'(OFF_STATUS));
    assign hit_clear  = (paddr == ADDR_W'(OFF_CLEAR));

    assign unused_hi = ^pwdata[DATA_W-1:8];

    // Control and period register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            range_q <= '0;
        end else begin
            if (wr_acc && hit_ctrl) begin
                ctrl_q <= ctrl_t'(pwdata[$bits(ctrl_t)-1:0]);
            end
            if (wr_acc && hit_range) begin
                range_q <= range_t'(pwdata[$bits(range_t)-1:0]);
            end
        end
    end

    // Strobes toward the counter and the response logic
    always_comb begin
        en_rise = wr_acc && hit_ctrl && pwdata[0] && !ctrl_q.en;
        kick    = wr_acc && hit_kick && (pwdata[7:0] == KICK_KEY) && ctrl_q.en;
        irq_clr = rd_acc && hit_clear;
    end

    // Read data multiplexer, free of side effects
    always_comb begin
        prdata = '0;
        unique case (1'b1)
            hit_ctrl:   prdata = DATA_W'(ctrl_q);
            hit_range:  prdata = DATA_W'(range_q);
            hit_count:  prdata = DATA_W'(cnt_val);
            hit_status: prdata = DATA_W'(irq_pend);
            default:    prdata = '0;
        endcase
    end

endmodule

// File: rtl/keyed_wdt_counter.sv
// Module: the watchdog down-counter.
// It loads 2^(BASE_EXP+sel)-1 from a table built in a generate loop. It uses
// the initial selection on enable and the running one on kick or expiry.
// expire is high in the cycle an enabled counter sits at zero.
// Assumes BASE_EXP + N_SEL - 1 <= CNT_W.
module keyed_wdt_counter
    import keyed_wdt_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned BASE_EXP = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             en_rise,
    input  logic             kick,
    input  logic [SEL_W-1:0] run_sel,
    input  logic [SEL_W-1:0] init_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    logic [CNT_W-1:0] load_tab [N_SEL];

    // One reload constant per period selection
    for (genvar g = 0; g < N_SEL; g++) begin : g_load
        localparam logic [CNT_W-1:0] LOAD_VAL =
            {CNT_W{1'b1}} >> (CNT_W - BASE_EXP - g);
        assign load_tab[g] = LOAD_VAL;
    end

    assign expire = en && (cnt == '0);

    // Counter update: load on enable, reload on kick or expiry, else count down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en_rise) begin
            cnt <= load_tab[init_sel];
        end else if (en) begin
            if (expire || kick) begin
                cnt <= load_tab[run_sel];
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/keyed_wdt_respond.sv
// Module: the expiry response.
// It keeps the pending interrupt and generates the reset pulse, which lasts
// 2^(pw+1) clocks from the cycle after an expiry that calls for a reset.
// Assumes expire is a one-cycle strobe and that a read clear loses to a new set.
module keyed_wdt_respond
    import keyed_wdt_pkg::*;
#(
    parameter int unsigned PW_BITS = PW_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               expire,
    input  logic               mode,
    input  logic [PW_BITS-1:0] pw,
    input  logic               irq_clr,
    output logic               irq,
    output logic               wdt_rst
);

    localparam int unsigned PULSE_MAX = 2 ** (2 ** PW_BITS);
    localparam int unsigned PCNT_W    = $clog2(PULSE_MAX + 1);

    logic              fire;
    logic [PCNT_W-1:0] pcnt;

    assign fire = expire && (!mode || irq);

    // Pending interrupt: set by the first-stage expiry, cleared by a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (expire && mode && !irq) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

    // Pulse length counter and registered reset output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt    <= '0;
            wdt_rst <= 1'b0;
        end else if (fire) begin
            pcnt    <= PCNT_W'(2) << pw;
            wdt_rst <= 1'b1;
        end else begin
            if (pcnt != '0) begin
                pcnt <= pcnt - 1'b1;
            end
            wdt_rst <= (pcnt > PCNT_W'(1));
        end
    end

endmodule

// File: rtl/keyed_wdt.sv
// Module: top of the keyed watchdog.
// It ties the register file, the down-counter and the expiry response
// together. BASE_EXP scales every period: selection i counts 2^(BASE_EXP+i).
// Assumes one clock for the bus and the counter, with a synchronous active-low reset.
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned BASE_EXP = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              irq,
    output logic              wdt_rst
);

    ctrl_t            ctrl_q;
    range_t           range_q;
    logic             ctrl_en, ctrl_mode;
    logic             en_rise, kick, irq_clr, expire;
    logic [CNT_W-1:0] cnt;

    assign ctrl_en   = ctrl_q.en;
    assign ctrl_mode = ctrl_q.mode;

    keyed_wdt_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .cnt_val  (cnt),
        .irq_pend (irq),
        .prdata   (prdata),
        .ctrl_q   (ctrl_q),
        .range_q  (range_q),
        .en_rise  (en_rise),
        .kick     (kick),
        .irq_clr  (irq_clr)
    );

    keyed_wdt_counter #(
        .CNT_W    (CNT_W),
        .BASE_EXP (BASE_EXP)
    ) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl_en),
        .en_rise  (en_rise),
        .kick     (kick),
        .run_sel  (range_q.run_sel),
        .init_sel (range_q.init_sel),
        .cnt      (cnt),
        .expire   (expire)
    );

    keyed_wdt_respond #(
        .PW_BITS (PW_W)
    ) respond_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .mode    (ctrl_mode),
        .pw      (ctrl_q.pw),
        .irq_clr (irq_clr),
        .irq     (irq),
        .wdt_rst (wdt_rst)
    );

endmodule

// File: rtl/keyed_wdt_chk.sv
// Checker: temporal properties of the keyed watchdog. It is bound into the
// top module and observes the strobes between its submodules.
// Assumes the synchronous active-low reset is held for at least one clock.
module keyed_wdt_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_en,
    input logic             ctrl_mode,
    input logic             en_rise,
    input logic             kick,
    input logic             irq_clr,
    input logic             expire,
    input logic [CNT_W-1:0] cnt,
    input logic             irq,
    input logic             wdt_rst
);

    // R2: an enabled counter with no reload in the last cycle steps down by one
    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && $past(ctrl_en) && !$past(kick) && !$past(expire))
        |-> (cnt == $past(cnt) - CNT_W'(1)));

    // R2: a disabled counter holds its value
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !$past(ctrl_en)) |-> $stable(cnt));

    // R3: enabling leaves a running, nonzero counter
    p_first_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (ctrl_en && cnt != '0));

    // R6: every expiry reloads the counter
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt != '0));

    // R7: direct mode resets on the clock after expiry
    p_direct_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ctrl_mode) |=> wdt_rst);

    // R7: the reset output rises only after an expiry
    p_reset_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |-> $past(expire));

    // R8: the first staged expiry raises the interrupt and no reset
    p_stage_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl_mode && !irq) |=> (irq && !$rose(wdt_rst)));

    // R9: the second staged expiry with the interrupt pending resets
    p_stage_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl_mode && irq) |=> (wdt_rst && irq));

    // R10: a read of the clear register drops the interrupt
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(expire && ctrl_mode && !irq)) |=> !irq);

endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_en   (ctrl_en),
    .ctrl_mode (ctrl_mode),
    .en_rise   (en_rise),
    .kick      (kick),
    .irq_clr   (irq_clr),
    .expire    (expire),
    .cnt       (cnt),
    .irq       (irq),
    .wdt_rst   (wdt_rst)
);

// File: tb/keyed_wdt_tb_top.sv
// Bench: directed scenarios plus a behavioural reference model. The model
// is compared with prdata, irq and wdt_rst on every clock.
// Inputs change on the falling edge and outputs are sampled 5 ns after it.
module keyed_wdt_tb_top;

    localparam int BASE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = 8'h08;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq, wdt_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit live = 1'b0;

    always #10 clk = ~clk;

    keyed_wdt #(.ADDR_W(8), .CNT_W(32), .BASE_EXP(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .irq(irq), .wdt_rst(wdt_rst)
    );

    // Reference model state
    int     m_en, m_mode, m_pw, m_top, m_init, m_irq, m_pulse;
    longint m_cnt;

    function automatic longint ld(int sel);
        return (longint'(1) << (BASE + sel)) - 1;
    endfunction

    function automatic longint m_read(logic [7:0] a);
        case (a)
            8'h00:   return longint'(m_en + 2 * m_mode + 4 * m_pw);
            8'h04:   return longint'(m_top + 16 * m_init);
            8'h08:   return m_cnt;
            8'h10:   return longint'(m_irq);
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Model update on each rising edge, from the bus inputs driven beforehand
    always @(posedge clk) begin : model
        bit wr, rd, ex, kk, rise, fire;
        longint n_cnt;
        int n_irq;
        if (!rst_n) begin
            m_en = 0; m_mode = 0; m_pw = 0; m_top = 0; m_init = 0;
            m_irq = 0; m_pulse = 0; m_cnt = 0;
        end else begin
            wr   = psel && penable && pwrite;
            rd   = psel && penable && !pwrite;
            ex   = (m_en != 0) && (m_cnt == 0);
            kk   = wr && paddr == 8'h0C && pwdata[7:0] == 8'h76 && m_en != 0;
            rise = wr && paddr == 8'h00 && pwdata[0] && m_en == 0;
            fire = ex && (m_mode == 0 || m_irq != 0);
            n_cnt = m_cnt;
            if (rise) n_cnt = ld(m_init);
            else if (m_en != 0) n_cnt = (ex || kk) ? ld(m_top) : m_cnt - 1;
            n_irq = (rd && paddr == 8'h14) ? 0 : m_irq;
            if (ex && m_mode != 0 && m_irq == 0) n_irq = 1;
            if (fire) m_pulse = 2 << m_pw;
            else if (m_pulse > 0) m_pulse--;
            if (wr && paddr == 8'h00) begin
                m_en = int'(pwdata[0]); m_mode = int'(pwdata[1]); m_pw = int'(pwdata[4:2]);
            end
            if (wr && paddr == 8'h04) begin
                m_top = int'(pwdata[3:0]); m_init = int'(pwdata[7:4]);
            end
            m_cnt = n_cnt;
            m_irq = n_irq;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        #5;
        if (live) begin
            check("R7 R9 wdt_rst vs model", longint'(wdt_rst), longint'(m_pulse != 0));
            check("R8 R10 irq vs model", longint'(irq), longint'(m_irq));
            check("R11 prdata vs model", longint'(prdata), m_read(paddr));
        end
    end

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = 8'h08; pwdata = '0;
    endtask

    task automatic bus_rd(logic [7:0] a, output longint v);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #5 v = longint'(prdata);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; paddr = 8'h08;
    endtask

    task automatic peek(output longint v);
        #5 v = longint'(prdata);
    endtask

    task automatic wait_zero();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            #5;
            if (prdata == 32'd0) break;
        end
    endtask

    task automatic pulse_len(output int w);
        w = 0;
        @(negedge clk);
        #5;
        while (wdt_rst && w < 1000) begin
            w++;
            @(negedge clk);
            #5;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        longint v, v2;
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;

        // R1: reset state
        check("R1 wdt_rst after reset", longint'(wdt_rst), 0);
        check("R1 irq after reset", longint'(irq), 0);
        bus_rd(8'h00, v); check("R1 control reads zero", v, 0);
        bus_rd(8'h04, v); check("R1 period reads zero", v, 0);
        bus_rd(8'h08, v); check("R1 counter reads zero", v, 0);
        bus_rd(8'h10, v); check("R1 status reads zero", v, 0);

        // R11: period register readback; init=2, run=1
        bus_wr(8'h04, 32'h0000_0021);
        bus_rd(8'h04, v); check("R11 period readback", v, 32'h21);
        bus_rd(8'h0C, v); check("R11 restart reads zero", v, 0);

        // R3: enable loads from the initial field: 2^(4+2)-1
        bus_wr(8'h00, 32'h1);
        peek(v); check("R3 first load", v, 63);

        // R2: counts down by one per clock
        repeat (10) @(negedge clk);
        peek(v); check("R2 count down", v, 53);

        // R5: wrong key ignored, counter keeps going (3 clocks in the write)
        bus_wr(8'h0C, 32'h55);
        peek(v); check("R5 wrong key ignored", v, 50);

        // R4: correct key reloads from the running field: 2^(4+1)-1
        bus_wr(8'h0C, 32'h76);
        peek(v); check("R4 kick reload", v, 31);

        // R6 and R7: direct mode expiry, width code 0 gives 2 clocks
        repeat (31) @(negedge clk);
        peek(v); check("R6 counter reaches zero", v, 0);
        @(negedge clk);
        peek(v); check("R6 reload after expiry", v, 31);
        check("R7 reset asserted after expiry", longint'(wdt_rst), 1);
        @(negedge clk); #5;
        check("R7 reset still high", longint'(wdt_rst), 1);
        @(negedge clk); #5;
        check("R7 reset low after 2 clocks", longint'(wdt_rst), 0);

        // R7: width code 3 gives 16 clocks; R11 control readback
        bus_wr(8'h00, 32'h0D);
        bus_rd(8'h00, v); check("R11 control readback", v, 32'h0D);
        wait_zero();
        pulse_len(w); check("R7 pulse width code 3", w, 16);

        // R8: staged mode with width code 1 (4 clocks)
        bus_wr(8'h00, 32'h07);
        wait_zero();
        @(negedge clk); #5;
        check("R8 irq raised", longint'(irq), 1);
        check("R8 no reset on first stage", longint'(wdt_rst), 0);
        bus_rd(8'h10, v); check("R8 status bit set", v, 1);

        // R9: second expiry with the interrupt still pending
        wait_zero();
        pulse_len(w); check("R9 staged reset width", w, 4);
        check("R9 irq still pending", longint'(irq), 1);

        // R10: read-to-clear, then the next expiry only interrupts
        bus_rd(8'h14, v);
        #5 check("R10 irq cleared by read", longint'(irq), 0);
        bus_rd(8'h10, v); check("R10 status cleared", v, 0);
        wait_zero();
        @(negedge clk); #5;
        check("R10 irq raised again", longint'(irq), 1);
        check("R10 no reset after clear", longint'(wdt_rst), 0);

        // R2: disabled counter holds
        bus_wr(8'h00, 32'h00);
        peek(v);
        repeat (6) @(negedge clk);
        peek(v2); check("R2 hold while disabled", v2, v);

        // R3: re-enable uses the new initial field: 2^(4+3)-1
        bus_wr(8'h04, 32'h30);
        bus_wr(8'h00, 32'h01);
        peek(v); check("R3 re-enable load", v, 127);
        bus_wr(8'h0C, 32'h0000_1276);
        peek(v); check("R4 kick with key in low byte", v, 15);

        // R5: kick while disabled has no effect
        bus_wr(8'h00, 32'h00);
        peek(v);
        bus_wr(8'h0C, 32'h76);
        peek(v2); check("R5 kick ignored while disabled", v2, v);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule